// File: doc/BRIEF.md
# Tap-Select Delay Timer

This block is a clocked, synthesizable timer-counter with trigger and stop controls. A time base, either an external one-cycle tick strobe or an internal divider of the system clock, advances an eight-bit binary counter while a run flop is set. The eight counter bits are brought out as active-low taps. Tap k reads low until 2^k ticks have passed since the start of a cycle. A program mask picks which taps are joined into one timing output. That output is low while any selected tap is low, which is how open-drain outputs behave when they are wired together.

In one-shot mode the rising edge of the joined output ends the cycle. The pulse on the timing output therefore lasts as many ticks as the mask value, anywhere from 1 to 255. In free-running mode the counter wraps until an external stop edge arrives. Both trigger and stop pass through a two-flop synchronizer and an edge detector before they are used. A trigger edge wins over a stop edge in the same cycle. While a cycle is running, a trigger edge on its own is ignored.

Top module: `tap_delay_timer`

## Requirements
- R1: After reset, and whenever no cycle is running, `taps_n_o` is all ones, `timing_o` is 1 and `tbase_n_o` is 1.
- R2: A rising edge on `trig_i` that is held across three clock edges starts a cycle at the third edge. From then on `taps_n_o` reads 8'h00, which is a counter value of zero.
- R3: A rising edge on `stop_i` ends a running cycle, and `taps_n_o` returns to all ones.
- R4: When trigger and stop edges arrive in the same cycle, the trigger wins. From idle, a cycle starts. While running, the cycle restarts with the count at zero.
- R5: While a cycle runs, a trigger edge without a stop edge has no effect, and the count keeps its value.
- R6: While running, `taps_n_o[k]` equals bit k of the number of ticks since the start (0 means low). Tap k is therefore a square wave with a period of 2^(k+1) ticks.
- R7: In one-shot mode (`oneshot_i`=1) with a nonzero mask, `timing_o` is low while any tap selected by a 1 in `mask_i` is low. The tick that would take every selected tap high ends the cycle, so `timing_o` stays low for exactly `mask_i` ticks.
- R8: In free-running mode (`oneshot_i`=0) the count wraps from 255 to 0 and the cycle goes on. `timing_o` is 1 while all selected taps are high, for example at count 255 with mask 8'hFF.
- R9: While idle, ticks are ignored and `tbase_n_o` stays high. While running, `tbase_n_o` is low during each cycle in which a tick is counted.
- R10: In one-shot mode a mask of zero behaves as free-running. `timing_o` stays 1 and the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger request, asynchronous; its rising edge counts |
| stop_i | input | 1 | Stop request, asynchronous; its rising edge counts |
| tick_i | input | 1 | One-cycle time-base strobe, used when the internal divider is off |
| oneshot_i | input | 1 | 1 = the joined output ends the cycle; 0 = free-running |
| mask_i | input | 8 | Selects the taps joined into `timing_o` |
| taps_n_o | output | 8 | Active-low counter taps |
| timing_o | output | 1 | Joined output, low while any selected tap is low |
| tbase_n_o | output | 1 | Active-low time-base pulse |

## Verification
The bench measures the one-shot pulse length for several masks, including a single low tap, the top tap alone, a sparse pattern and all ones. A feedback stop that fired one tick early or late, or that looked at unselected taps, would give a count other than the mask value. It sends a trigger in the middle of a run and simultaneous trigger and stop edges, both from idle and while running. A design without lockout would clear the count, and one that let stop win would leave the taps high. Free-running operation is followed past the wrap at 255, and so is one-shot mode with a zero mask. Either case would stall or end early if feedback were applied wrongly.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
   typedef enum logic {
      RS_IDLE = 1'b0,
      RS_RUN  = 1'b1
   } run_state_e;

   localparam int unsigned CTL_NUM = 2;
   localparam int unsigned CTL_TRIG = 0;
   localparam int unsigned CTL_STOP = 1;
endpackage

// File: rtl/tdt_edge_sync.sv
module tdt_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tdt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tdt_timebase.sv
module tdt_timebase #(
   parameter bit          USE_INT_DIV = 1'b0,
   parameter int unsigned DIV_RATIO   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic tick_o
);
   if (USE_INT_DIV) begin : g_div
      if (DIV_RATIO < 2) begin : g_bad_ratio
         $error("tdt_timebase: DIV_RATIO must be at least 2");
      end
      localparam int unsigned DIV_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

      logic [DIV_W-1:0] div_q;
      logic             unused_tick;
      assign unused_tick = tick_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             div_q <= '0;
         else if (!run_i)        div_q <= '0;
         else if (div_q == DIV_LAST) div_q <= '0;
         else                    div_q <= div_q + DIV_W'(1);
      end

      assign tick_o = run_i && (div_q == DIV_LAST);
   end else begin : g_ext
      assign tick_o = run_i & tick_i;
   end

   assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> run_i);
endmodule

// File: rtl/tdt_tap_counter.sv
module tdt_tap_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + W'(1);
   end

   assign cnt_o = cnt_q;

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clear_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/tap_delay_timer.sv
module tap_delay_timer #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_INT_DIV = 1'b0,
   parameter int unsigned DIV_RATIO   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             stop_i,
   input  logic             tick_i,
   input  logic             oneshot_i,
   input  logic [CNT_W-1:0] mask_i,
   output logic [CNT_W-1:0] taps_n_o,
   output logic             timing_o,
   output logic             tbase_n_o
);
   import tdt_pkg::*;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("tap_delay_timer: CNT_W must be in 2..16");
   end

   localparam logic [CNT_W-1:0] TAPS_IDLE = {CNT_W{1'b1}};

   // synchronised control edges
   logic [CTL_NUM-1:0] raw_ctl;
   logic [CTL_NUM-1:0] rise_ctl;
   assign raw_ctl[CTL_TRIG] = trig_i;
   assign raw_ctl[CTL_STOP] = stop_i;

   for (genvar g = 0; g < CTL_NUM; g++) begin : g_sync
      tdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .din_i  (raw_ctl[g]),
         .rise_o (rise_ctl[g])
      );
   end

   logic trig_rise, stop_rise;
   assign trig_rise = rise_ctl[CTL_TRIG];
   assign stop_rise = rise_ctl[CTL_STOP];

   // control flip-flop
   run_state_e       run_q, run_d;
   logic             running;
   logic             tick_int;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_next;
   logic             fb_hit, stop_any, start;

   assign running  = (run_q == RS_RUN);
   assign cnt_next = cnt + CNT_W'(1);

   // feedback: the tick that would lift every selected tap ends the cycle
   assign fb_hit   = oneshot_i && (|mask_i) && tick_int &&
                     ((cnt_next & mask_i) == mask_i);
   assign stop_any = stop_rise | fb_hit;
   assign start    = trig_rise & (~running | stop_any);

   always_comb begin
      run_d = run_q;
      if (start)         run_d = RS_RUN;
      else if (stop_any) run_d = RS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= RS_IDLE;
      else        run_q <= run_d;
   end

   tdt_timebase #(.USE_INT_DIV(USE_INT_DIV), .DIV_RATIO(DIV_RATIO)) u_tbase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (running),
      .tick_i (tick_i),
      .tick_o (tick_int)
   );

   tdt_tap_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start | stop_any),
      .inc_i   (tick_int),
      .cnt_o   (cnt)
   );

   assign taps_n_o  = running ? cnt : TAPS_IDLE;
   assign timing_o  = running ? (&(cnt | ~mask_i)) : 1'b1;
   assign tbase_n_o = ~tick_int;

   assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (taps_n_o == '0));

   assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_rise && stop_rise) |=> (running && cnt == '0));

   assert_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && trig_rise && !stop_rise && !tick_int && !fb_hit) |=>
         (running && $stable(cnt)));

   assert_oneshot_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && oneshot_i && (|mask_i) && tick_int && !trig_rise &&
       ((taps_n_o + CNT_W'(1)) & mask_i) == mask_i) |=> (timing_o && !running));

   assert_idle_tbase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tbase_n_o |-> (taps_n_o != TAPS_IDLE || running));
endmodule

// File: tb/tap_delay_timer_bench.sv
module tap_delay_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       tick_i = 1'b0;
   logic       oneshot_i = 1'b0;
   logic [7:0] mask_i = 8'h00;
   logic [7:0] taps_n_o;
   logic       timing_o;
   logic       tbase_n_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tap_delay_timer u_tap_delay_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_i),
      .stop_i    (stop_i),
      .tick_i    (tick_i),
      .oneshot_i (oneshot_i),
      .mask_i    (mask_i),
      .taps_n_o  (taps_n_o),
      .timing_o  (timing_o),
      .tbase_n_o (tbase_n_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ctl_edge(input bit do_trig, input bit do_stop);
      @(negedge clk);
      trig_i = do_trig;
      stop_i = do_stop;
      repeat (3) @(negedge clk);
      trig_i = 1'b0;
      stop_i = 1'b0;
      #1;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic one_tick(output bit tb_low);
      @(negedge clk);
      tick_i = 1'b1;
      #1 tb_low = !tbase_n_o;
      @(negedge clk);
      tick_i = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 taps idle", taps_n_o, 8'hFF);
      chk("R1 timing idle", timing_o, 1);
      chk("R1 tbase idle", tbase_n_o, 1);
   endtask

   task automatic t_idle_tick();
      bit lo;
      one_tick(lo);
      chk("R9 tbase idle tick", lo, 0);
      chk("R9 taps after idle tick", taps_n_o, 8'hFF);
   endtask

   task automatic t_delay(input logic [7:0] m);
      bit lo;
      int n = 0;
      oneshot_i = 1'b1;
      mask_i = m;
      ctl_edge(1'b1, 1'b0);
      chk("R2 taps at start", taps_n_o, 8'h00);
      chk("R7 timing low at start", timing_o, 0);
      while (timing_o == 1'b0 && n < 300) begin
         one_tick(lo);
         if (n == 0) chk("R9 tbase pulse", lo, 1);
         n++;
      end
      chk("R7 pulse length", n, m);
      chk("R7 taps after end", taps_n_o, 8'hFF);
      settle();
   endtask

   task automatic t_stop();
      bit lo;
      oneshot_i = 1'b0;
      mask_i = 8'h10;
      ctl_edge(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) one_tick(lo);
      chk("R6 taps after 5 ticks", taps_n_o, 8'h05);
      ctl_edge(1'b0, 1'b1);
      chk("R3 taps after stop", taps_n_o, 8'hFF);
      chk("R3 timing after stop", timing_o, 1);
      settle();
   endtask

   task automatic t_lockout();
      bit lo;
      oneshot_i = 1'b0;
      mask_i = 8'h80;
      ctl_edge(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) one_tick(lo);
      settle();
      ctl_edge(1'b1, 1'b0);
      chk("R5 count kept after retrigger", taps_n_o, 8'h03);
      one_tick(lo);
      chk("R5 still counting", taps_n_o, 8'h04);
      ctl_edge(1'b0, 1'b1);
      settle();
   endtask

   task automatic t_priority();
      bit lo;
      oneshot_i = 1'b0;
      mask_i = 8'h80;
      ctl_edge(1'b1, 1'b1);
      chk("R4 start from idle", taps_n_o, 8'h00);
      for (int i = 0; i < 6; i++) one_tick(lo);
      chk("R4 counting", taps_n_o, 8'h06);
      settle();
      ctl_edge(1'b1, 1'b1);
      chk("R4 restart while running", taps_n_o, 8'h00);
      ctl_edge(1'b0, 1'b1);
      settle();
   endtask

   task automatic t_astable();
      bit lo;
      int bad = 0;
      bit saw_high = 1'b0;
      oneshot_i = 1'b0;
      mask_i = 8'hFF;
      ctl_edge(1'b1, 1'b0);
      for (int k = 1; k <= 300; k++) begin
         one_tick(lo);
         if (taps_n_o != 8'(k)) bad++;
         if (8'(k) == 8'hFF && timing_o) saw_high = 1'b1;
      end
      chk("R6 tap sequence mismatches", bad, 0);
      chk("R8 timing high at 255", saw_high, 1);
      chk("R8 wrapped count", taps_n_o, 300 % 256);
      ctl_edge(1'b0, 1'b1);
      settle();
   endtask

   task automatic t_zero_mask();
      bit lo;
      oneshot_i = 1'b1;
      mask_i = 8'h00;
      ctl_edge(1'b1, 1'b0);
      chk("R10 timing high", timing_o, 1);
      for (int k = 0; k < 260; k++) one_tick(lo);
      chk("R10 keeps running", taps_n_o, 260 % 256);
      chk("R10 timing still high", timing_o, 1);
      ctl_edge(1'b0, 1'b1);
      settle();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_idle_tick();
      t_delay(8'h01);
      t_delay(8'h05);
      t_delay(8'h2A);
      t_delay(8'h80);
      t_delay(8'hFF);
      t_stop();
      t_lockout();
      t_priority();
      t_astable();
      t_zero_mask();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule